// File: doc/BRIEF.md
# Locality-Register Reduced-Tag Cache

This block is a direct-mapped, write-through cache whose tag array keeps only a short slice of each address tag. The high part of the tag is held once, in a single locality register that names the memory region the program is working in. Every CPU access compares the locality register and the short per-line tag side by side. A hit is reported only when both agree, so two addresses that share the short tag but lie in different regions can never be confused.

When a read falls outside the current region, a small saturating counter decides what happens next. While the counter is below its maximum, the read is served straight from memory and the cache is left as it is. Once the counter has saturated, the locality register takes the new region, every line is invalidated in one cycle and the read fills the cache. Writes always go through to memory. A write allocates its line only when it falls inside the current region.

Top module: `lrt_cache`

## Requirements
- R1: After reset `rsp_ready` and `mem_req` are low, every line is invalid and the locality register is marked empty.
- R2: The first read after reset reloads the locality register whatever the counter holds, fetches the word from memory and returns it.
- R3: A read whose region and short tag both match a valid line is answered in the cycle it is presented (`rsp_ready` high combinationally), with the cached word, and with no memory request.
- R4: A read inside the region whose short tag differs from the indexed line's tag fetches from memory and replaces that line. The old address then misses.
- R5: An address with the same index and short tag as a cached line but different upper tag bits never hits. It returns memory data.
- R6: The counter saturates at 2^CNT_W−1 (7 by default) and counts consecutive out-of-region reads. In-region reads clear it. An out-of-region read reloads the locality register only if the counter is already saturated. With defaults, seven such reads in a row leave the region unchanged and the eighth reloads it.
- R7: A reload invalidates every line in the same cycle. Lines filled under the old region then miss.
- R8: Every write issues one memory write with the request's address and data (`mem_we` high). A write inside the region also stores the word in its line, so the next read hits with the new data.
- R9: A write outside the region reaches memory only. It changes neither the cache, the locality register nor the counter.
- R10: An out-of-region read that does not reload (bypass) allocates no line, so repeating it goes to memory again.
- R11: Any memory-served access completes in the cycle `mem_ack` is high. On a read, `rsp_rdata` then carries `mem_rdata`. `mem_req` stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present; held until `rsp_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write word |
| rsp_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | DATA_W | Read word, valid with `rsp_ready` |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W | Memory read word, valid with `mem_ack` |

## Verification
A stale valid bit or a missed invalidation shows at the ports on the first read that reuses the line's index and short tag under a new region. That read answers with zero latency, raises no memory request and returns the old region's word. A wrong counter or locality value shows as a change in memory traffic: reads that should hit go to memory, or out-of-region reads start hitting. Each scenario reads back right after the disturbing access, so a corrupted state is exposed within one or two accesses.

// File: rtl/lrt_cache.sv
module lrt_cache #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 10,
  parameter int KTAG_W = 5,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [(8<<OFF_W)-1:0]   req_wdata,
  output logic                    rsp_ready,
  output logic [(8<<OFF_W)-1:0]   rsp_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [(8<<OFF_W)-1:0]   mem_wdata,
  input  logic                    mem_ack,
  input  logic [(8<<OFF_W)-1:0]   mem_rdata
);
  localparam int DATA_W = 8 << OFF_W;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int UP_W   = TAG_W - KTAG_W;
  localparam int LINES  = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_BYP, S_WR} st_t;

  st_t                st_q;
  logic [ADDR_W-1:0]  a_q;
  logic [DATA_W-1:0]  wd_q;
  logic [UP_W-1:0]    loc_q;
  logic               loc_ok;
  logic [LINES-1:0]   vld_q;
  logic [KTAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0]  dat_q [LINES];

  wire [IDX_W-1:0]  r_idx = req_addr[OFF_W +: IDX_W];
  wire [KTAG_W-1:0] r_kt  = req_addr[OFF_W+IDX_W +: KTAG_W];
  wire [UP_W-1:0]   r_up  = req_addr[ADDR_W-1 -: UP_W];
  wire [IDX_W-1:0]  a_idx = a_q[OFF_W +: IDX_W];
  wire [KTAG_W-1:0] a_kt  = a_q[OFF_W+IDX_W +: KTAG_W];

  wire loc_match = loc_ok && (r_up == loc_q);
  wire tag_match = vld_q[r_idx] && (tag_q[r_idx] == r_kt);
  wire go        = (st_q == S_IDLE) && req_valid;
  wire rd        = go && !req_we;
  wire wr        = go && req_we;
  logic sat;
  wire rd_hit    = rd && loc_match && tag_match;
  wire reload    = rd && !loc_match && sat;
  wire bypass    = rd && !loc_match && !sat;
  wire fill      = reload || (rd && loc_match && !tag_match);

  generate
    if (CNT_W > 0) begin : g_cnt
      localparam logic [CNT_W-1:0] CMAX = '1;
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (reload)              cnt_q <= '0;
        else if (rd && loc_match)     cnt_q <= '0;
        else if (bypass)              cnt_q <= cnt_q + 1'b1;
      end
      assign sat = !loc_ok || (cnt_q == CMAX);
      assert_reload_saturated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && loc_ok) |-> (cnt_q == CMAX));
      assert_bypass_below_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (cnt_q != '0));
    end else begin : g_nocnt
      assign sat = 1'b1;
    end
  endgenerate

  assign rsp_ready = rd_hit || ((st_q != S_IDLE) && mem_ack);
  assign rsp_rdata = rd_hit ? dat_q[r_idx] : mem_rdata;
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = a_q;
  assign mem_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      loc_q  <= '0;
      loc_ok <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (go) begin
            a_q  <= req_addr;
            wd_q <= req_wdata;
          end
          if (reload) begin
            loc_q  <= r_up;
            loc_ok <= 1'b1;
          end
          if (fill)        st_q <= S_FILL;
          else if (bypass) st_q <= S_BYP;
          else if (wr)     st_q <= S_WR;
        end
        default: if (mem_ack) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            vld_q <= '0;
    else if (reload)                       vld_q <= '0;
    else if (wr && loc_match)              vld_q[r_idx] <= 1'b1;
    else if (st_q == S_FILL && mem_ack)    vld_q[a_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr && loc_match) begin
      tag_q[r_idx] <= r_kt;
      dat_q[r_idx] <= req_wdata;
    end else if (st_q == S_FILL && mem_ack) begin
      tag_q[a_idx] <= a_kt;
      dat_q[a_idx] <= mem_rdata;
    end
  end

  assert_reload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (vld_q == '0));
  assert_hit_needs_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !mem_req) |-> (loc_ok && req_addr[ADDR_W-1 -: UP_W] == loc_q));
  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_hit_no_memory_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> !mem_req);
endmodule

// File: tb/tb_lrt_cache.sv
`timescale 1ns/1ps
module tb_lrt_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_ready, mem_req, mem_we;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0, dly = 0;
  logic [31:0] wmem [bit [31:0]];
  logic [31:0] last_waddr, last_wdata;
  localparam logic [14:0] RA = 15'h0011, RB = 15'h0222;

  always #2.5 clk = ~clk;

  lrt_cache dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [31:0] mdef(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_1234;
  endfunction
  function automatic logic [31:0] mk(input logic [14:0] up, input logic [4:0] kt, input logic [9:0] ix);
    return {up, kt, ix, 2'b00};
  endfunction
  function automatic logic [31:0] mval(input logic [31:0] a);
    return wmem.exists(a) ? wmem[a] : mdef(a);
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (dly == 2) begin
        dly = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wmem[mem_addr] = mem_wdata;
          last_waddr = mem_addr; last_wdata = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata <= mval(mem_addr);
          n_rd++;
        end
      end else dly++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rdat, output int mops, output int lat);
    int r0 = n_rd + n_wr;
    lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    forever begin
      #1;
      if (rsp_ready) break;
      @(negedge clk);
      lat++;
    end
    rdat = rsp_rdata;
    mops = n_rd + n_wr - r0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mops = n_rd + n_wr - r0;
  endtask

  task automatic rd_expect(input logic [31:0] a, input int exp_mops, input string rq);
    logic [31:0] d; int m, l;
    access(1'b0, a, '0, d, m, l);
    chk(m == exp_mops, rq, m, exp_mops);
    chk(d == mval(a), rq, d, mval(a));
    if (exp_mops == 0) chk(l == 0, rq, l, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rsp_ready == 1'b0, "R1", rsp_ready, 0);
    chk(mem_req == 1'b0, "R1", mem_req, 0);
  endtask

  task automatic t_first();
    rd_expect(mk(RA, 3, 5), 1, "R2");
    rd_expect(mk(RA, 3, 5), 0, "R3");
    rd_expect(mk(RA, 6, 7), 1, "R11");
    rd_expect(mk(RA, 6, 7), 0, "R3");
  endtask

  task automatic t_conflict();
    rd_expect(mk(RA, 9, 5), 1, "R4");
    rd_expect(mk(RA, 3, 5), 1, "R4");
    rd_expect(mk(RA, 3, 5), 0, "R4");
  endtask

  task automatic t_false_hit();
    rd_expect(mk(RB, 3, 5), 1, "R5");
    rd_expect(mk(RA, 3, 5), 0, "R10");
    rd_expect(mk(RB, 3, 5), 1, "R10");
    rd_expect(mk(RA, 3, 5), 0, "R5");
  endtask

  task automatic t_hyst();
    for (int i = 0; i < 7; i++) rd_expect(mk(RB, 1, 10'(20 + i)), 1, "R6");
    rd_expect(mk(RA, 3, 5), 0, "R6");
    for (int i = 0; i < 8; i++) rd_expect(mk(RB, 1, 10'(40 + i)), 1, "R6");
    rd_expect(mk(RB, 1, 47), 0, "R6");
    rd_expect(mk(RB, 3, 5), 1, "R7");
    rd_expect(mk(RB, 6, 7), 1, "R7");
    rd_expect(mk(RA, 3, 5), 1, "R6");
  endtask

  task automatic t_write();
    logic [31:0] d; int m, l;
    access(1'b1, mk(RB, 2, 60), 32'hDEAD_BEEF, d, m, l);
    chk(m == 1, "R8", m, 1);
    chk(last_waddr == mk(RB, 2, 60), "R8", last_waddr, mk(RB, 2, 60));
    chk(last_wdata == 32'hDEAD_BEEF, "R8", last_wdata, 32'hDEAD_BEEF);
    rd_expect(mk(RB, 2, 60), 0, "R8");
    access(1'b1, mk(RB, 1, 47), 32'hCAFE_0047, d, m, l);
    chk(m == 1, "R8", m, 1);
    rd_expect(mk(RB, 1, 47), 0, "R8");
    access(1'b1, mk(RA, 2, 61), 32'h1234_5678, d, m, l);
    chk(m == 1, "R9", m, 1);
    chk(last_wdata == 32'h1234_5678, "R9", last_wdata, 32'h1234_5678);
    rd_expect(mk(RB, 1, 47), 0, "R9");
    rd_expect(mk(RA, 2, 61), 1, "R9");
    rd_expect(mk(RB, 2, 60), 0, "R9");
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_first();
    t_conflict();
    t_false_hit();
    t_hyst();
    t_write();
    finish_up();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    finish_up();
  end
endmodule